// File: doc/BRIEF.md
# Circular DMA controller

The controller moves data for up to twelve independent channels over a single bus master port. A channel is programmed through a load port with a source address, a destination address, a beat count, a direction, a data size for each side, an increment enable for each side and a circular flag. Loading a non-zero count enables the channel.

Each beat is one read at the source followed by one write at the destination. The read is truncated to the source size and then zero-extended or truncated to the destination size. Peripheral-paced channels perform one beat for each request or software trigger. Memory-to-memory channels run back to back once started. A fixed-priority arbiter chooses one channel per beat. When a non-circular channel uses up its count it disables itself and pulses a transfer-complete line. A circular channel instead reloads its start addresses and count and keeps running, and it raises no interrupt at the wrap.

Top module: `circ_dma`

## Requirements
- R1: Channels programmed with direction code 00 (peripheral to memory), 01 (memory to peripheral) or 11 are peripheral-paced. Such a channel starts a beat only while its `req_i` bit is high or a software trigger is pending. With neither present the bus stays idle.
- R2: On an enabled peripheral-paced channel, a one-cycle `sw_trig_i` pulse yields exactly one beat and no acknowledge. On a disabled channel it has no effect.
- R3: A channel with direction code 10 (memory to memory) is started by a trigger or a request. From then on it runs all of its counted beats back to back with no further trigger.
- R4: A beat drives a read (`bus_we_o`=0) at the source address with the source size, and then a write (`bus_we_o`=1) at the destination address with the destination size. Valid, address, size and write enable stay stable while `bus_ready_i` is low.
- R5: Size codes are 00 byte, 01 halfword, and 10 or 11 word. Data sits in the low bits of the bus. Read data is masked to the source size. Write data is that value zero-extended or truncated to the destination size, and its unused upper bits are zero.
- R6: When its increment enable is set, a side's address advances by 1, 2 or 4 per beat according to that side's size. When the enable is clear, the address stays fixed.
- R7: `ack_o[i]` pulses for exactly one cycle, in the cycle after the write of a beat of channel i is accepted. It pulses only if `req_i[i]` was high at that acceptance and the channel is peripheral-paced.
- R8: The beat count is 16 bits wide. A non-circular channel that finishes its last beat disables itself and pulses `tc_o[i]` for one cycle, in the cycle after the final write is accepted. Later triggers on that channel are ignored.
- R9: A circular channel reloads its start addresses and count after its last beat and continues. It never pulses `tc_o`.
- R10: Among pending channels the lowest index wins. Arbitration is repeated for every beat, so a lower channel that becomes pending preempts a running higher channel at the next beat boundary.
- R11: Loading a channel with count 0 leaves it disabled. Doing so to a running channel stops it after at most its in-flight beat.
- R12: While reset is asserted and after its release, `bus_valid_o`, `ack_o` and `tc_o` are low and every channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Program the channel selected by cfg_ch_i |
| cfg_ch_i | input | 4 | Channel index to program |
| cfg_dir_i | input | 2 | Direction code |
| cfg_src_i | input | 32 | Source start address |
| cfg_dst_i | input | 32 | Destination start address |
| cfg_cnt_i | input | 16 | Beat count, 0 disables |
| cfg_ssz_i | input | 2 | Source size code |
| cfg_dsz_i | input | 2 | Destination size code |
| cfg_sinc_i | input | 1 | Source increment enable |
| cfg_dinc_i | input | 1 | Destination increment enable |
| cfg_circ_i | input | 1 | Circular mode |
| sw_trig_i | input | 12 | Software trigger, one bit per channel |
| req_i | input | 12 | Hardware request, one bit per channel |
| ack_o | output | 12 | Request acknowledge pulses |
| tc_o | output | 12 | Transfer-complete pulses |
| bus_valid_o | output | 1 | Bus access valid |
| bus_we_o | output | 1 | Bus write enable |
| bus_addr_o | output | 32 | Bus address |
| bus_size_o | output | 2 | Bus access size code |
| bus_wdata_o | output | 32 | Write data, low aligned |
| bus_rdata_i | input | 32 | Read data, low aligned |
| bus_ready_i | input | 1 | Access accepted this cycle |

## Verification
The bench sweeps all nine source and destination size pairs against all four increment combinations, with and without bus stalls. A block that skipped masking or stepped by the wrong size would leave stray upper bytes or misplaced bytes in the destination image. A peripheral request is held high until its acknowledge arrives, so a design that re-arbitrated the channel in the acknowledge cycle would issue a spurious extra beat. A lower channel is triggered just after a higher one has completed its first beat, which catches a design that keeps a channel to the end of its count. A circular channel is run across two wraps and then stopped by a zero-count load; a wrong reload address, a stray transfer-complete pulse or a channel that will not stop each show up as a mismatch.

// File: rtl/circ_dma_pkg.sv
`timescale 1ns/1ps
package circ_dma_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    DIR_P2M = 2'b00,
    DIR_M2P = 2'b01,
    DIR_M2M = 2'b10,
    DIR_RSV = 2'b11
  } dir_e;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   return 32'h0000_00ff;
      2'b01:   return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/circ_dma_chan.sv
`timescale 1ns/1ps
module circ_dma_chan
  import circ_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [1:0]    dir_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [1:0]    ssz_i,
  input  logic [1:0]    dsz_i,
  input  logic          sinc_i,
  input  logic          dinc_i,
  input  logic          circ_i,
  input  logic          sw_trig_i,
  input  logic          req_i,
  input  logic          served_i,
  output logic          pend_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [1:0]    ssz_o,
  output logic [1:0]    dsz_o,
  output logic          ack_o,
  output logic          tc_o
);
  logic          en_q, run_q, swp_q, ack_q, tc_q;
  logic          m2m_q, sinc_q, dinc_q, circ_q;
  logic [1:0]    ssz_q, dsz_q;
  logic [AW-1:0] src_q, dst_q, src_base_q, dst_base_q;
  logic [CW-1:0] cnt_q, cnt_base_q;
  logic          last;

  assign last = (cnt_q == CW'(1));
  // a channel whose ack is in flight is masked so a held request is not served twice
  assign pend_o = en_q & (m2m_q ? run_q : ((req_i & ~ack_q) | swp_q));
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign ssz_o  = ssz_q;
  assign dsz_o  = dsz_q;
  assign ack_o  = ack_q;
  assign tc_o   = tc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; run_q <= 1'b0; swp_q <= 1'b0; ack_q <= 1'b0; tc_q <= 1'b0;
      m2m_q <= 1'b0; sinc_q <= 1'b0; dinc_q <= 1'b0; circ_q <= 1'b0;
      ssz_q <= '0; dsz_q <= '0;
      src_q <= '0; dst_q <= '0; src_base_q <= '0; dst_base_q <= '0;
      cnt_q <= '0; cnt_base_q <= '0;
    end else begin
      ack_q <= served_i & ~m2m_q & req_i;
      tc_q  <= served_i & last & ~circ_q;
      if (load_i) begin
        en_q       <= (cnt_i != '0);
        run_q      <= 1'b0;
        swp_q      <= 1'b0;
        m2m_q      <= (dir_i == DIR_M2M);
        sinc_q     <= sinc_i;
        dinc_q     <= dinc_i;
        circ_q     <= circ_i;
        ssz_q      <= ssz_i;
        dsz_q      <= dsz_i;
        src_q      <= src_i;
        dst_q      <= dst_i;
        src_base_q <= src_i;
        dst_base_q <= dst_i;
        cnt_q      <= cnt_i;
        cnt_base_q <= cnt_i;
      end else begin
        if (en_q && m2m_q && (sw_trig_i || req_i)) run_q <= 1'b1;
        if (en_q && !m2m_q) swp_q <= sw_trig_i | (swp_q & ~(served_i & ~req_i));
        if (served_i) begin
          if (last) begin
            if (circ_q) begin
              src_q <= src_base_q;
              dst_q <= dst_base_q;
              cnt_q <= cnt_base_q;
            end else begin
              en_q  <= 1'b0;
              run_q <= 1'b0;
              swp_q <= 1'b0;
              cnt_q <= '0;
            end
          end else begin
            cnt_q <= cnt_q - CW'(1);
            src_q <= src_q + (sinc_q ? AW'(size_bytes(ssz_q)) : '0);
            dst_q <= dst_q + (dinc_q ? AW'(size_bytes(dsz_q)) : '0);
          end
        end
      end
    end
  end
endmodule

// File: rtl/circ_dma_arb.sv
`timescale 1ns/1ps
module circ_dma_arb #(
  parameter int N  = 12,
  parameter int IW = 4
) (
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  assign any_o = |pend_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/circ_dma_xfer.sv
`timescale 1ns/1ps
module circ_dma_xfer
  import circ_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [1:0]        ssz_i,
  input  logic [1:0]        dsz_i,
  output logic [IW-1:0]     sel_o,
  output logic              done_o,
  output logic              bus_valid_o,
  output logic              bus_we_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;

  st_e               st_q;
  logic [IW-1:0]     sel_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      hold_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (any_i) begin
          sel_q <= idx_i;
          st_q  <= ST_RD;
        end
        ST_RD: if (bus_ready_i) begin
          hold_q <= bus_rdata_i & size_mask(ssz_i);
          st_q   <= ST_WR;
        end
        ST_WR:   if (bus_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_o       = sel_q;
  assign bus_valid_o = (st_q != ST_IDLE);
  assign bus_we_o    = (st_q == ST_WR);
  assign bus_addr_o  = bus_we_o ? dst_i : src_i;
  assign bus_size_o  = bus_we_o ? dsz_i : ssz_i;
  assign bus_wdata_o = bus_we_o ? (hold_q & size_mask(dsz_i)) : '0;
  assign done_o      = (st_q == ST_WR) && bus_ready_i;
endmodule

// File: rtl/circ_dma.sv
`timescale 1ns/1ps
module circ_dma
  import circ_dma_pkg::*;
#(
  parameter int N_CH = 12,
  parameter int AW   = 32,
  parameter int CW   = 16,
  localparam int IW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_load_i,
  input  logic [IW-1:0]     cfg_ch_i,
  input  logic [1:0]        cfg_dir_i,
  input  logic [AW-1:0]     cfg_src_i,
  input  logic [AW-1:0]     cfg_dst_i,
  input  logic [CW-1:0]     cfg_cnt_i,
  input  logic [1:0]        cfg_ssz_i,
  input  logic [1:0]        cfg_dsz_i,
  input  logic              cfg_sinc_i,
  input  logic              cfg_dinc_i,
  input  logic              cfg_circ_i,
  input  logic [N_CH-1:0]   sw_trig_i,
  input  logic [N_CH-1:0]   req_i,
  output logic [N_CH-1:0]   ack_o,
  output logic [N_CH-1:0]   tc_o,
  output logic              bus_valid_o,
  output logic              bus_we_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [1:0]        bus_size_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ready_i
);
  logic [N_CH-1:0] pend;
  logic [AW-1:0]   src_a [N_CH];
  logic [AW-1:0]   dst_a [N_CH];
  logic [1:0]      ssz_a [N_CH];
  logic [1:0]      dsz_a [N_CH];
  logic            any;
  logic [IW-1:0]   idx, sel;
  logic            done;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    circ_dma_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (cfg_load_i && (cfg_ch_i == IW'(g))),
      .dir_i     (cfg_dir_i),
      .src_i     (cfg_src_i),
      .dst_i     (cfg_dst_i),
      .cnt_i     (cfg_cnt_i),
      .ssz_i     (cfg_ssz_i),
      .dsz_i     (cfg_dsz_i),
      .sinc_i    (cfg_sinc_i),
      .dinc_i    (cfg_dinc_i),
      .circ_i    (cfg_circ_i),
      .sw_trig_i (sw_trig_i[g]),
      .req_i     (req_i[g]),
      .served_i  (done && (sel == IW'(g))),
      .pend_o    (pend[g]),
      .src_o     (src_a[g]),
      .dst_o     (dst_a[g]),
      .ssz_o     (ssz_a[g]),
      .dsz_o     (dsz_a[g]),
      .ack_o     (ack_o[g]),
      .tc_o      (tc_o[g])
    );
  end

  circ_dma_arb #(.N(N_CH), .IW(IW)) u_arb (
    .pend_i (pend),
    .any_o  (any),
    .idx_o  (idx)
  );

  circ_dma_xfer #(.AW(AW), .IW(IW)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .any_i       (any),
    .idx_i       (idx),
    .src_i       (src_a[sel]),
    .dst_i       (dst_a[sel]),
    .ssz_i       (ssz_a[sel]),
    .dsz_i       (dsz_a[sel]),
    .sel_o       (sel),
    .done_o      (done),
    .bus_valid_o (bus_valid_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_size_o  (bus_size_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_ready_i (bus_ready_i)
  );
endmodule

// File: rtl/circ_dma_chk.sv
`timescale 1ns/1ps
module circ_dma_chk #(
  parameter int N_CH = 12,
  parameter int AW   = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] ack_o,
  input logic [N_CH-1:0] tc_o,
  input logic            bus_valid_o,
  input logic            bus_we_o,
  input logic [AW-1:0]   bus_addr_o,
  input logic [1:0]      bus_size_o,
  input logic [31:0]     bus_wdata_o,
  input logic            bus_ready_i
);
  assert_bus_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=>
      (bus_valid_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_size_o)));

  assert_read_then_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_we_o && bus_ready_i) |=> (bus_valid_o && bus_we_o));

  assert_wdata_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_we_o) |->
      ((bus_size_o != 2'b00 || bus_wdata_o[31:8] == '0) &&
       (bus_size_o != 2'b01 || bus_wdata_o[31:16] == '0)));

  assert_ack_after_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != '0) |-> $past(bus_valid_o && bus_we_o && bus_ready_i));

  assert_ack_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != '0) |=> ((ack_o & $past(ack_o)) == '0));

  assert_tc_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o != '0) |=> ((tc_o & $past(tc_o)) == '0));

  assert_single_chan_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o) && $onehot0(tc_o));

  assert_reset_quiet_R12: assert property (@(posedge clk_i)
    !rst_ni |-> (!bus_valid_o && ack_o == '0 && tc_o == '0));
endmodule

bind circ_dma circ_dma_chk #(.N_CH(N_CH), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_o       (ack_o),
  .tc_o        (tc_o),
  .bus_valid_o (bus_valid_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_size_o  (bus_size_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ready_i (bus_ready_i)
);

// File: tb/circ_dma_test.sv
`timescale 1ns/1ps
module circ_dma_test;
  import circ_dma_pkg::*;
  localparam int N = 12, AW = 32, CW = 16, IW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_load_i = 1'b0;
  logic [IW-1:0] cfg_ch_i = '0;
  logic [1:0] cfg_dir_i = '0, cfg_ssz_i = '0, cfg_dsz_i = '0;
  logic [AW-1:0] cfg_src_i = '0, cfg_dst_i = '0;
  logic [CW-1:0] cfg_cnt_i = '0;
  logic cfg_sinc_i = 1'b0, cfg_dinc_i = 1'b0, cfg_circ_i = 1'b0;
  logic [N-1:0] sw_trig_i = '0, req_i = '0;
  logic [N-1:0] ack_o, tc_o;
  logic bus_valid_o, bus_we_o, bus_ready_i;
  logic [AW-1:0] bus_addr_o;
  logic [1:0] bus_size_o;
  logic [31:0] bus_wdata_o, bus_rdata_i;

  always #5 clk_i = ~clk_i;

  circ_dma uut (.*);

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic stall_en = 1'b0, rdy_t = 1'b0;
  wire [7:0] ba = bus_addr_o[7:0];

  always @(posedge clk_i) rdy_t <= ~rdy_t;
  assign bus_ready_i = stall_en ? rdy_t : 1'b1;
  assign bus_rdata_i = {mem[ba + 8'd3], mem[ba + 8'd2], mem[ba + 8'd1], mem[ba]};

  always @(posedge clk_i) begin
    if (bus_valid_o && bus_we_o && bus_ready_i)
      for (int k = 0; k < 4; k++)
        if (k < int'(size_bytes(bus_size_o))) mem[ba + 8'(k)] <= bus_wdata_o[8*k +: 8];
  end

  int checks = 0, fails = 0;
  int wr_n = 0, ack_bad = 0;
  logic [7:0] wr_addr [512];
  int tc_cnt [N];
  int ack_cnt [N];
  logic wr_prev = 1'b0;

  initial for (int i = 0; i < N; i++) begin tc_cnt[i] = 0; ack_cnt[i] = 0; end

  always @(negedge clk_i) begin
    if (ack_o != '0 && !wr_prev) ack_bad++;
    wr_prev = bus_valid_o && bus_we_o && bus_ready_i;
    if (wr_prev) begin
      if (wr_n < 512) wr_addr[wr_n] = bus_addr_o[7:0];
      wr_n++;
    end
    for (int i = 0; i < N; i++) begin
      if (tc_o[i]) tc_cnt[i]++;
      if (ack_o[i]) ack_cnt[i]++;
    end
  end

  task automatic tick();
    @(negedge clk_i); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic load_ch(input int ch, input logic [1:0] dir, input logic [7:0] src,
                         input logic [7:0] dst, input int cnt, input logic [1:0] ssz,
                         input logic [1:0] dsz, input bit sinc, input bit dinc, input bit circ);
    cfg_ch_i = IW'(ch); cfg_dir_i = dir; cfg_src_i = AW'(src); cfg_dst_i = AW'(dst);
    cfg_cnt_i = CW'(cnt); cfg_ssz_i = ssz; cfg_dsz_i = dsz;
    cfg_sinc_i = sinc; cfg_dinc_i = dinc; cfg_circ_i = circ;
    cfg_load_i = 1'b1;
    tick();
    cfg_load_i = 1'b0;
  endtask

  task automatic trig(input int ch);
    sw_trig_i = '0; sw_trig_i[ch] = 1'b1;
    tick();
    sw_trig_i = '0;
  endtask

  task automatic wait_tc(input int ch, input int base, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (tc_cnt[ch] > base) break;
      tick();
    end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    report();
    $finish;
  end

  initial begin
    int run, ch, t0, w0, a0, bad, bad_a, sb, db;
    logic [7:0] sa, da;
    logic [31:0] v;
    run = 0;
    for (int a = 0; a < 256; a++) mem[a] = 8'(a);

    // R12: quiet during and after reset
    ticks(2);
    check(bus_valid_o == 1'b0, "R12 bus_valid in reset", bus_valid_o, 0);
    check(ack_o == '0, "R12 ack in reset", ack_o, 0);
    check(tc_o == '0, "R12 tc in reset", tc_o, 0);
    rst_ni = 1'b1;
    tick();
    w0 = wr_n;
    trig(0); req_i = '1; ticks(20); req_i = '0;
    check(wr_n == w0, "R12 channels disabled after reset", wr_n - w0, 0);

    // R3 R4 R5 R6 R8: size and increment sweep, memory to memory
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 3; d++)
        for (int si = 0; si < 2; si++)
          for (int di = 0; di < 2; di++) begin
            ch = run % N;
            run++;
            stall_en = (si == di);
            for (int a = 0; a < 256; a++) begin
              mem[a] = 8'(a * 7 + run * 13 + 5);
              exp_mem[a] = mem[a];
            end
            sb = (s == 0) ? 1 : (s == 1) ? 2 : 4;
            db = (d == 0) ? 1 : (d == 1) ? 2 : 4;
            for (int i = 0; i < 4; i++) begin
              sa = 8'(16 + ((si != 0) ? i * sb : 0));
              da = 8'(128 + ((di != 0) ? i * db : 0));
              v = '0;
              for (int k = 0; k < sb; k++) v |= 32'(exp_mem[sa + 8'(k)]) << (8 * k);
              for (int k = 0; k < db; k++) exp_mem[da + 8'(k)] = v[8*k +: 8];
            end
            t0 = tc_cnt[ch]; w0 = wr_n;
            load_ch(ch, DIR_M2M, 8'h10, 8'h80, 4, 2'(s), 2'(d), si != 0, di != 0, 1'b0);
            trig(ch);
            wait_tc(ch, t0, 300);
            ticks(3);
            bad = 0; bad_a = 0;
            for (int a = 0; a < 256; a++)
              if (mem[a] !== exp_mem[a]) begin
                if (bad == 0) bad_a = a;
                bad++;
              end
            check(bad == 0, "R4 R5 R6 destination image", mem[bad_a], exp_mem[bad_a]);
            check(wr_n - w0 == 4, "R3 back-to-back beat count", wr_n - w0, 4);
            check(tc_cnt[ch] - t0 == 1, "R8 single tc pulse", tc_cnt[ch] - t0, 1);
          end
    stall_en = 1'b0;

    // R8: finished channel ignores triggers
    w0 = wr_n;
    trig(ch); ticks(20);
    check(wr_n == w0, "R8 trigger after completion ignored", wr_n - w0, 0);

    // R1 R7: request-paced channel 11
    for (int a = 0; a < 256; a++) mem[a] = 8'(255 - a);
    w0 = wr_n; t0 = tc_cnt[11]; a0 = ack_cnt[11];
    load_ch(11, DIR_P2M, 8'h30, 8'h90, 2, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0);
    ticks(20);
    check(wr_n == w0, "R1 no beat without request", wr_n - w0, 0);
    for (int b = 0; b < 2; b++) begin
      req_i[11] = 1'b1;
      for (int i = 0; i < 50; i++) begin
        tick();
        if (ack_o[11]) break;
      end
      req_i[11] = 1'b0;
    end
    ticks(5);
    check(wr_n - w0 == 2, "R1 one beat per request", wr_n - w0, 2);
    check(ack_cnt[11] - a0 == 2, "R7 ack pulses", ack_cnt[11] - a0, 2);
    check(ack_bad == 0, "R7 ack follows write", ack_bad, 0);
    check(tc_cnt[11] - t0 == 1, "R8 tc after count", tc_cnt[11] - t0, 1);
    check(mem[8'h90] == 8'(255 - 8'h30) && mem[8'h91] == 8'(255 - 8'h31),
          "R1 peripheral data", {mem[8'h91], mem[8'h90]}, {8'(255 - 8'h31), 8'(255 - 8'h30)});

    // R2: software trigger on peripheral-paced channel
    w0 = wr_n; t0 = tc_cnt[4]; a0 = ack_cnt[4];
    load_ch(4, DIR_M2P, 8'h40, 8'hB0, 3, 2'b10, 2'b10, 1'b1, 1'b1, 1'b0);
    trig(4); ticks(20);
    check(wr_n - w0 == 1, "R2 one beat per trigger", wr_n - w0, 1);
    check(ack_cnt[4] == a0, "R2 no ack for software beat", ack_cnt[4] - a0, 0);
    trig(4); ticks(20);
    check(wr_n - w0 == 2, "R2 second trigger beat", wr_n - w0, 2);
    check(tc_cnt[4] == t0, "R8 no tc before count done", tc_cnt[4] - t0, 0);

    // R10: lower channel preempts at beat boundary
    load_ch(5, DIR_M2M, 8'h50, 8'hC0, 4, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0);
    load_ch(2, DIR_M2M, 8'h60, 8'hD0, 3, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0);
    w0 = wr_n; t0 = tc_cnt[5];
    trig(5);
    for (int i = 0; i < 50; i++) begin
      if (wr_n > w0) break;
      tick();
    end
    trig(2);
    wait_tc(5, t0, 200);
    ticks(3);
    begin
      logic [7:0] order [7];
      order = '{8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hC1, 8'hC2, 8'hC3};
      check(wr_n - w0 == 7, "R10 total beats", wr_n - w0, 7);
      for (int k = 0; k < 7; k++)
        check(wr_addr[w0 + k] == order[k], "R10 priority order", wr_addr[w0 + k], order[k]);
    end

    // R9 R11: circular run, then stop with zero count
    t0 = tc_cnt[1];
    load_ch(1, DIR_M2M, 8'h70, 8'hE0, 3, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1);
    w0 = wr_n;
    trig(1);
    for (int i = 0; i < 100; i++) begin
      if (wr_n >= w0 + 8) break;
      tick();
    end
    load_ch(1, DIR_M2M, 8'h70, 8'hE0, 0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1);
    ticks(5);
    a0 = wr_n;
    ticks(20);
    check(wr_n == a0, "R11 zero-count load stops channel", wr_n - a0, 0);
    for (int k = 0; k < 8; k++)
      check(wr_addr[w0 + k] == 8'(8'hE0 + k % 3), "R9 circular wrap address",
            wr_addr[w0 + k], 8'(8'hE0 + k % 3));
    check(tc_cnt[1] == t0, "R9 no tc in circular mode", tc_cnt[1] - t0, 0);
    check(mem[8'hE2] == mem[8'h72], "R9 circular data", mem[8'hE2], mem[8'h72]);

    // R11: zero count never enables
    load_ch(6, DIR_P2M, 8'h00, 8'hF0, 0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0);
    w0 = wr_n;
    trig(6); req_i[6] = 1'b1; ticks(20); req_i[6] = 1'b0;
    check(wr_n == w0, "R11 zero count stays disabled", wr_n - w0, 0);

    check(ack_bad == 0, "R7 ack alignment overall", ack_bad, 0);
    report();
    $finish;
  end
endmodule